// File: doc/BRIEF.md
# Byte FIFO Pair with Event and Interrupt Logic

This block sits between a 32-bit register bus and a serial shift engine. It holds two byte-wide queues of 32 entries each. Software fills the transmit queue and empties the receive queue through one data address per direction. Each bus access can be 1, 2 or 4 bytes wide. A multi-byte access moves its bytes in big-endian order, so the most significant byte of the access is the first byte in the queue. The shift engine reaches the other end of each queue through a plain byte pop and byte push interface, and it raises a one-cycle pulse when a transfer is finished.

A status word reports how many bytes wait in the receive queue and how much room is left in the transmit queue. The same word carries the event flags. Four flags follow the live queue state: transmit empty, transmit not full, receive full and receive not empty. Three flags latch until software clears them by writing ones: transfer done, receive threshold and transmit threshold. A mask register uses the same bit positions as the event flags, and the interrupt output is high while any event flag and its mask bit are both set. A mode register holds the two threshold levels.

The registers sit at byte offsets on the bus. Bits 4:2 of the address select them: 0x00 mode, 0x04 events, 0x08 mask, 0x0C transmit data, 0x10 receive data. Read data is registered and appears one clock after the read strobe.

Top module: `byte_fifo_evt`

## Requirements
- R1: After reset, the event word reads 0x00208900 (transmit free 32, receive count 0, transmit empty, transmit threshold, transmit not full), the mode register reads 0x0000040F, the mask reads 0 and irq is low.
- R2: A transmit write with bus_size 2 or 3 queues bus_wdata[31:24], [23:16], [15:8], [7:0] in that order. With bus_size 1 it queues [15:8] then [7:0], and with bus_size 0 it queues [7:0]. sh_tx_byte shows the oldest byte and sh_tx_pop removes it.
- R3: A receive read returns the oldest bytes first, in big-endian packing: 4 bytes fill [31:24] down to [7:0], 2 bytes fill [15:8] and [7:0], 1 byte fills [7:0], and all unused bits are zero.
- R4: A transmit write whose byte count exceeds the free space is dropped whole, and the queue contents and free count stay unchanged.
- R5: A receive read whose byte count exceeds the bytes held returns 0 and removes nothing. This includes a read of an empty queue.
- R6: Event word bits 29:24 give the receive byte count and bits 21:16 give the free transmit bytes. All bits not listed in R6 to R9 read zero.
- R7: Live flags: bit 15 is set while the transmit queue is empty, bit 8 while it is not full, bit 12 while the receive queue holds 32 bytes, and bit 9 while it is not empty. A shift push into a full receive queue is ignored.
- R8: Mode bits 15:8 hold the transmit threshold and bits 7:0 the receive threshold. Bit 13 latches when the receive count exceeds the receive threshold. Bit 11 latches when the transmit count falls below the transmit threshold. Both stay set until cleared.
- R9: Bit 14 latches on an sh_done pulse and stays set until cleared.
- R10: A write to the event address clears each latched flag whose bit in bus_wdata[15:8] is one and leaves the other flags alone. A flag whose set condition still holds sets again.
- R11: The mask register holds bits 15:8. irq is high exactly while an event bit and its mask bit are both one.
- R12: A bus access and a shift access to the same queue in one cycle both take effect. Space and fill level are judged on the count before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset; bits 4:2 select the register |
| bus_size | input | 2 | Data access width: 0 byte, 1 half, 2 or 3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| sh_tx_pop | input | 1 | Shift side removes the oldest transmit byte |
| sh_tx_byte | output | 8 | Oldest transmit byte, 0 when empty |
| sh_rx_push | input | 1 | Shift side appends a received byte |
| sh_rx_byte | input | 8 | Received byte |
| sh_done | input | 1 | Transfer finished pulse |

## Verification
The two functions that can fall in the same cycle are the bus access and the shift access to the same queue. On the transmit side a data write can meet a pop, and on the receive side a data read can meet a push. The bench drives both strobes on the same falling edge. It checks that the popped or read byte is the old head, that the appended byte follows it in order, and that the count field shows the net change. It also repeats the transmit case with a full queue, where the write must be dropped because the space is judged before the pop.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

    localparam int unsigned LANES = 4;

    typedef enum logic [2:0] {
        SEL_MODE = 3'd0,
        SEL_EVT  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_TXD  = 3'd3,
        SEL_RXD  = 3'd4
    } reg_sel_e;

    // positions inside the event byte (word bits 15:8)
    localparam int unsigned EB_TNF = 0;
    localparam int unsigned EB_RNE = 1;
    localparam int unsigned EB_TXT = 3;
    localparam int unsigned EB_RXF = 4;
    localparam int unsigned EB_RXT = 5;
    localparam int unsigned EB_DON = 6;
    localparam int unsigned EB_TXE = 7;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bfe_fifo.sv
module bfe_fifo #(
    parameter  int unsigned DEPTH = 32,
    parameter  int unsigned LANES = 4,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1,
    localparam int unsigned NW    = $clog2(LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NW-1:0]              push_n,
    input  logic [LANES-1:0][7:0]      push_data,
    input  logic [NW-1:0]              pop_n,
    output logic [LANES-1:0][7:0]      peek,
    output logic [CW-1:0]              count
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(LANES); i++) begin
            if (i < int'(push_n)) begin
                mem[wr_ptr + AW'(i)] <= push_data[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            peek[i] = mem[rd_ptr + AW'(i)];
        end
    end

    // R4: the caller never pushes beyond free space
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) + int'(push_n)) <= int'(DEPTH));

    // R5: the caller never pops more than held
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(count));

endmodule

// File: rtl/bfe_events.sv
module bfe_events
    import bfe_pkg::*;
#(
    parameter  int unsigned DEPTH = 32,
    localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic [7:0]    tx_thr,
    input  logic [7:0]    rx_thr,
    input  logic          done_in,
    input  logic [7:0]    clr,
    input  logic [7:0]    mask,
    output logic [7:0]    ev,
    output logic          irq
);

    logic don_q, rxt_q, txt_q;
    logic set_rxt, set_txt;

    assign set_rxt = 9'(rx_cnt) > 9'(rx_thr);
    assign set_txt = 9'(tx_cnt) < 9'(tx_thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            don_q <= 1'b0;
            rxt_q <= 1'b0;
            txt_q <= 1'b0;
        end else begin
            don_q <= (don_q & ~clr[EB_DON]) | done_in;
            rxt_q <= (rxt_q & ~clr[EB_RXT]) | set_rxt;
            txt_q <= (txt_q & ~clr[EB_TXT]) | set_txt;
        end
    end

    always_comb begin
        ev         = '0;
        ev[EB_TXE] = (tx_cnt == '0);
        ev[EB_DON] = don_q;
        ev[EB_RXT] = rxt_q;
        ev[EB_RXF] = (rx_cnt == CW'(DEPTH));
        ev[EB_TXT] = txt_q;
        ev[EB_RNE] = (rx_cnt != '0);
        ev[EB_TNF] = (tx_cnt != CW'(DEPTH));
        irq        = |(ev & mask);
    end

    a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(don_q) |-> $past(done_in));

    a_r7_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EB_RXF] |-> ev[EB_RNE]);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[EB_DON] && !done_in) |=> !don_q);

    a_r8_rxt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rxt_q && !clr[EB_RXT]) |=> rxt_q);

    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

// File: rtl/byte_fifo_evt.sv
module byte_fifo_evt
    import bfe_pkg::*;
#(
    parameter  int unsigned DEPTH = 32,
    localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        sh_tx_pop,
    output logic [7:0]  sh_tx_byte,
    input  logic        sh_rx_push,
    input  logic [7:0]  sh_rx_byte,
    input  logic        sh_done
);

    reg_sel_e             sel;
    logic [2:0]           nb;
    logic [CW-1:0]        tx_cnt, rx_cnt, tx_free;
    logic [LANES-1:0][7:0] tx_lane, tx_peek, rx_lane, rx_peek;
    logic [2:0]           tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [CW-1:0]        tx_push_w;
    logic [7:0]           tx_thr, rx_thr, mask_q, clr, ev;
    logic [31:0]          rx_word, rd_next;
    logic                 tx_ok, rx_ok;

    assign sel     = reg_sel_e'(bus_addr[4:2]);
    assign nb      = size_bytes(bus_size);
    assign tx_free = CW'(DEPTH) - tx_cnt;

    // transmit side: all-or-nothing bus push, single-byte shift pop
    assign tx_ok     = bus_wr && (sel == SEL_TXD) && (CW'(nb) <= tx_free);
    assign tx_push_n = tx_ok ? nb : 3'd0;
    assign tx_push_w = CW'(tx_push_n);
    assign tx_pop_n  = (sh_tx_pop && tx_cnt != '0) ? 3'd1 : 3'd0;

    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            tx_lane[i] = '0;
            if (i < int'(nb)) begin
                tx_lane[i] = 8'(bus_wdata >> (8 * (int'(nb) - 1 - i)));
            end
        end
    end

    // receive side: single-byte shift push, all-or-nothing bus pop
    assign rx_push_n = (sh_rx_push && rx_cnt != CW'(DEPTH)) ? 3'd1 : 3'd0;
    assign rx_ok     = bus_rd && (sel == SEL_RXD) && (CW'(nb) <= rx_cnt);
    assign rx_pop_n  = rx_ok ? nb : 3'd0;

    always_comb begin
        rx_lane    = '0;
        rx_lane[0] = sh_rx_byte;
        rx_word    = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (i < int'(nb)) begin
                rx_word = rx_word | (32'(rx_peek[i]) << (8 * (int'(nb) - 1 - i)));
            end
        end
    end

    bfe_fifo #(.DEPTH(DEPTH), .LANES(LANES)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(tx_lane),
        .pop_n(tx_pop_n), .peek(tx_peek), .count(tx_cnt)
    );

    bfe_fifo #(.DEPTH(DEPTH), .LANES(LANES)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_data(rx_lane),
        .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
    );

    assign clr = (bus_wr && sel == SEL_EVT) ? bus_wdata[15:8] : 8'h00;

    bfe_events #(.DEPTH(DEPTH)) events_i (
        .clk(clk), .rst_n(rst_n),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .done_in(sh_done), .clr(clr), .mask(mask_q),
        .ev(ev), .irq(irq)
    );

    assign sh_tx_byte = (tx_cnt != '0) ? tx_peek[0] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr <= 8'd4;
            rx_thr <= 8'd15;
            mask_q <= 8'h00;
        end else if (bus_wr) begin
            case (sel)
                SEL_MODE: begin
                    tx_thr <= bus_wdata[15:8];
                    rx_thr <= bus_wdata[7:0];
                end
                SEL_MASK: mask_q <= bus_wdata[15:8];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: rd_next = {16'h0000, tx_thr, rx_thr};
            SEL_EVT:  rd_next = {2'b00, 6'(rx_cnt), 2'b00, 6'(tx_free), ev, 8'h00};
            SEL_MASK: rd_next = {16'h0000, mask_q, 8'h00};
            SEL_RXD:  rd_next = rx_ok ? rx_word : 32'h0;
            default:  rd_next = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_TXD && CW'(nb) > tx_free && !sh_tx_pop)
        |=> (tx_cnt == $past(tx_cnt)));

    a_r5_short_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_RXD && CW'(nb) > rx_cnt) |=> (bus_rdata == 32'h0));

    a_r12_tx_net_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_n != 3'd0 && tx_pop_n != 3'd0)
        |=> (tx_cnt == $past(tx_cnt) + $past(tx_push_w) - CW'(1)));

endmodule

// File: tb/byte_fifo_evt_tb_top.sv
`timescale 1ns/1ps
module byte_fifo_evt_tb_top;

    localparam logic [4:0] A_MODE = 5'h00;
    localparam logic [4:0] A_EVT  = 5'h04;
    localparam logic [4:0] A_MASK = 5'h08;
    localparam logic [4:0] A_TXD  = 5'h0C;
    localparam logic [4:0] A_RXD  = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        sh_tx_pop = 1'b0;
    logic [7:0]  sh_tx_byte;
    logic        sh_rx_push = 1'b0;
    logic [7:0]  sh_rx_byte = '0;
    logic        sh_done = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    byte_fifo_evt dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq),
        .sh_tx_pop(sh_tx_pop), .sh_tx_byte(sh_tx_byte),
        .sh_rx_push(sh_rx_push), .sh_rx_byte(sh_rx_byte),
        .sh_done(sh_done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = s;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic sh_push(input logic [7:0] b);
        @(negedge clk);
        sh_rx_push = 1'b1; sh_rx_byte = b;
        @(negedge clk);
        sh_rx_push = 1'b0;
    endtask

    task automatic sh_pop(output logic [7:0] b);
        @(negedge clk);
        b = sh_tx_byte; sh_tx_pop = 1'b1;
        @(negedge clk);
        sh_tx_pop = 1'b0;
    endtask

    task automatic clear_all();
        bus_write(A_EVT, 2'd2, 32'hFFFF_FFFF);
    endtask

    task automatic test_reset();
        logic [31:0] r;
        bus_read(A_EVT, 2'd2, r);  check("R1", "event word after reset", r, 32'h0020_8900);
        bus_read(A_MODE, 2'd2, r); check("R1", "mode after reset", r, 32'h0000_040F);
        bus_read(A_MASK, 2'd2, r); check("R1", "mask after reset", r, 32'h0);
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic test_tx_order();
        logic [31:0] r;
        logic [7:0] b;
        logic [7:0] exp_b [7] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h55, 8'h66, 8'h77};
        bus_write(A_TXD, 2'd2, 32'hA1B2_C3D4);
        bus_write(A_TXD, 2'd1, 32'hFFFF_5566);
        bus_write(A_TXD, 2'd0, 32'hFFFF_FF77);
        clear_all();
        bus_read(A_EVT, 2'd2, r);
        check("R6", "event word with 7 queued", r, 32'h0019_0100);
        for (int k = 0; k < 7; k++) begin
            sh_pop(b);
            check("R2", "transmit byte order", {24'b0, b}, {24'b0, exp_b[k]});
        end
        repeat (2) @(negedge clk);
        bus_read(A_EVT, 2'd2, r);
        check("R7", "tx empty and threshold after drain", r & 32'h003F_8900, 32'h0020_8900);
    endtask

    task automatic test_rx_read();
        logic [31:0] r;
        for (int k = 1; k <= 7; k++) sh_push(8'(8'h11 * k));
        bus_read(A_RXD, 2'd2, r); check("R3", "word read", r, 32'h1122_3344);
        bus_read(A_RXD, 2'd1, r); check("R3", "half read", r, 32'h0000_5566);
        bus_read(A_RXD, 2'd0, r); check("R3", "byte read", r, 32'h0000_0077);
        bus_read(A_RXD, 2'd0, r); check("R5", "empty read", r, 32'h0);
        sh_push(8'hAA); sh_push(8'hBB); sh_push(8'hCC);
        bus_read(A_RXD, 2'd2, r); check("R5", "short word read", r, 32'h0);
        bus_read(A_EVT, 2'd2, r); check("R5", "count kept after short read", r[29:24], 32'd3);
        bus_read(A_RXD, 2'd1, r); check("R5", "half after short read", r, 32'h0000_AABB);
        bus_read(A_RXD, 2'd0, r); check("R5", "byte after short read", r, 32'h0000_00CC);
    endtask

    task automatic test_overflow();
        logic [31:0] r;
        logic [7:0] b;
        for (int j = 0; j < 8; j++)
            bus_write(A_TXD, 2'd2, {8'(4*j), 8'(4*j+1), 8'(4*j+2), 8'(4*j+3)});
        bus_read(A_EVT, 2'd2, r);
        check("R7", "full tx flags and free", r & 32'h003F_8100, 32'h0);
        bus_write(A_TXD, 2'd2, 32'hDEAD_BEEF);
        bus_read(A_EVT, 2'd2, r);
        check("R4", "free after dropped word", r[21:16], 32'd0);
        sh_pop(b);
        check("R2", "first byte of full queue", {24'b0, b}, 32'h0);
        bus_write(A_TXD, 2'd1, 32'h0000_EEEE);
        bus_read(A_EVT, 2'd2, r);
        check("R4", "free after dropped half", r[21:16], 32'd1);
        bus_write(A_TXD, 2'd0, 32'h0000_0020);
        bus_read(A_EVT, 2'd2, r);
        check("R4", "free after accepted byte", r[21:16], 32'd0);
        for (int k = 1; k <= 32; k++) begin
            sh_pop(b);
            check("R4", "order after refill", {24'b0, b}, 32'(k));
        end
    endtask

    task automatic test_thresholds();
        logic [31:0] r;
        logic [7:0] b;
        bus_write(A_MODE, 2'd2, 32'h0000_0203);
        bus_read(A_MODE, 2'd2, r); check("R8", "mode readback", r, 32'h0000_0203);
        clear_all();
        for (int k = 0; k < 3; k++) sh_push(8'(8'h10 + k));
        bus_read(A_EVT, 2'd2, r); check("R8", "rx threshold at equal count", {31'b0, r[13]}, 32'd0);
        sh_push(8'h13);
        bus_read(A_EVT, 2'd2, r); check("R8", "rx threshold above count", {31'b0, r[13]}, 32'd1);
        bus_read(A_RXD, 2'd0, r); check("R3", "byte read 0x10", r, 32'h10);
        bus_read(A_EVT, 2'd2, r); check("R8", "rx threshold persists", {31'b0, r[13]}, 32'd1);
        bus_write(A_EVT, 2'd2, 32'h0000_2000);
        bus_read(A_EVT, 2'd2, r); check("R10", "rx threshold cleared", {31'b0, r[13]}, 32'd0);
        for (int k = 0; k < 29; k++) sh_push(8'(8'h40 + k));
        bus_read(A_EVT, 2'd2, r); check("R7", "rx full flags", r & 32'h3F00_1200, 32'h2000_1200);
        sh_push(8'h99);
        bus_read(A_EVT, 2'd2, r); check("R7", "push into full ignored", r[29:24], 32'd32);
        bus_read(A_RXD, 2'd2, r); check("R3", "first word of full rx", r, 32'h1112_1340);
        for (int k = 0; k < 6; k++) bus_read(A_RXD, 2'd2, r);
        bus_read(A_RXD, 2'd2, r); check("R7", "last word excludes ignored byte", r, 32'h595A_5B5C);
        bus_read(A_EVT, 2'd2, r); check("R7", "rx empty flags", r & 32'h3F00_1200, 32'h0);
        bus_write(A_TXD, 2'd1, 32'h0000_0102);
        bus_write(A_EVT, 2'd2, 32'h0000_0800);
        bus_read(A_EVT, 2'd2, r); check("R8", "tx threshold at equal count", {31'b0, r[11]}, 32'd0);
        sh_pop(b);
        bus_read(A_EVT, 2'd2, r); check("R8", "tx threshold below count", {31'b0, r[11]}, 32'd1);
        sh_pop(b);
        bus_write(A_MODE, 2'd2, 32'h0000_040F);
    endtask

    task automatic test_done_irq();
        logic [31:0] r;
        clear_all();
        @(negedge clk); sh_done = 1'b1;
        @(negedge clk); sh_done = 1'b0;
        bus_read(A_EVT, 2'd2, r); check("R9", "done latched", {31'b0, r[14]}, 32'd1);
        bus_write(A_MASK, 2'd2, 32'h0000_4000);
        check("R11", "irq on masked done", {31'b0, irq}, 32'd1);
        bus_write(A_EVT, 2'd2, 32'h0000_0800);
        bus_read(A_EVT, 2'd2, r); check("R10", "done kept by other clear", {31'b0, r[14]}, 32'd1);
        bus_write(A_EVT, 2'd2, 32'h0000_4000);
        check("R11", "irq after done cleared", {31'b0, irq}, 32'd0);
        bus_read(A_EVT, 2'd2, r); check("R10", "done cleared", {31'b0, r[14]}, 32'd0);
        bus_write(A_MASK, 2'd2, 32'h0000_8000);
        check("R11", "irq on live tx empty", {31'b0, irq}, 32'd1);
        bus_write(A_MASK, 2'd2, 32'h0);
        check("R11", "irq with mask zero", {31'b0, irq}, 32'd0);
    endtask

    task automatic test_same_cycle();
        logic [31:0] r;
        logic [7:0] b;
        bus_write(A_TXD, 2'd1, 32'h0000_C1C2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_TXD; bus_size = 2'd0; bus_wdata = 32'h0000_00C3;
        sh_tx_pop = 1'b1; b = sh_tx_byte;
        @(negedge clk);
        bus_wr = 1'b0; sh_tx_pop = 1'b0;
        check("R12", "popped old head", {24'b0, b}, 32'h0000_00C1);
        bus_read(A_EVT, 2'd2, r); check("R12", "tx free after push+pop", r[21:16], 32'd30);
        sh_pop(b); check("R12", "second tx byte", {24'b0, b}, 32'h0000_00C2);
        sh_pop(b); check("R12", "pushed byte follows", {24'b0, b}, 32'h0000_00C3);
        sh_push(8'hD1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_RXD; bus_size = 2'd0;
        sh_rx_push = 1'b1; sh_rx_byte = 8'hD2;
        @(negedge clk);
        bus_rd = 1'b0; sh_rx_push = 1'b0;
        check("R12", "read old rx head", bus_rdata, 32'h0000_00D1);
        bus_read(A_RXD, 2'd0, r); check("R12", "pushed rx byte follows", r, 32'h0000_00D2);
        for (int j = 0; j < 8; j++) bus_write(A_TXD, 2'd2, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_TXD; bus_size = 2'd0; bus_wdata = 32'h0000_00EE;
        sh_tx_pop = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sh_tx_pop = 1'b0;
        bus_read(A_EVT, 2'd2, r); check("R12", "write to full dropped despite pop", r[21:16], 32'd1);
        for (int k = 0; k < 31; k++) sh_pop(b);
        bus_read(A_EVT, 2'd2, r); check("R12", "tx empty after drain", r[21:16], 32'd32);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_tx_order();
        test_rx_read();
        test_overflow();
        test_thresholds();
        test_done_irq();
        test_same_cycle();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL R1..all watchdog: got running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule